// File: doc/BRIEF.md
# Full-Step Bipolar Stepper Chopper Driver

This block drives a two-phase bipolar stepper through a dual H-bridge. Each of the two windings has a polarity line and a bridge enable. Each rising edge on the step input moves the motor one full step, forward or backward according to the direction input. A fixed-frequency chopper limits the winding current by gating both bridge enables. Each chop period starts with the enables on. They go off when the counter reaches the point set by the duty select, or earlier if an external current comparator trips.

The comparator compares the amplified sense-resistor voltage with a reference that a small DAC produces. This block supplies the code for that DAC. The code is a fixed parameter while the driver is enabled and zero while it is disabled.

The block has no data stream, so every pin is a plain control or status level. There is no valid/ready handshake and no back-pressure. The step and comparator inputs are asynchronous to the clock and pass through two-flop synchronizers.

Top module: `stepper_chopper_drive`

## Requirements
- R1: After reset the phase state is (A+,B+), so both polarity lines read 1. Both bridge enables are 0 while enable is low. The DAC code is 0 while enable is low.
- R2: A polarity line value of 1 means positive winding current. With direction high, each step moves through (A+,B+) → (A-,B+) → (A-,B-) → (A+,B-) → (A+,B+). With direction low, the steps move through the same cycle in reverse.
- R3: The step input passes through a two-flop synchronizer. The phase moves only on a rising edge, and by exactly one state per edge, however long the input stays high.
- R4: While enable is low, both bridge enables are 0 in the same cycle. Step edges are ignored, and the polarity lines keep the last phase.
- R5: The chop period is PERIOD clocks. From the start of each period, the enables stay on for PERIOD/4 × (duty_sel+1) clocks and then go off until the period ends. The duty_sel codes are 00 for 25%, 01 for 50%, 10 for 75% and 11 for 100%.
- R6: duty_sel is sampled only at a period boundary or while the driver is disabled. A new value therefore governs whole periods.
- R7: The comparator input passes through a two-flop synchronizer. When the synchronized value is high, the enables go off for the rest of the current period. They come back on at the start of the next period.
- R8: dac_ref equals the parameter IREF_CODE while enable is high and 0 while enable is low.
- R9: The two bridge enables are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_in | input | 1 | Step request; acts on its rising edge |
| dir_in | input | 1 | 1 steps forward, 0 steps backward |
| enable | input | 1 | Driver enable; low forces the bridge enables off |
| duty_sel | input | 2 | Chopper duty code: 00 25%, 01 50%, 10 75%, 11 100% |
| comp_trip | input | 1 | Current comparator output; high means over the limit |
| pol_a | output | 1 | Winding A polarity (1 = positive) |
| pol_b | output | 1 | Winding B polarity (1 = positive) |
| bridge_en_a | output | 1 | Winding A bridge enable |
| bridge_en_b | output | 1 | Winding B bridge enable |
| dac_ref | output | DAC_W | Reference code for the current-limit DAC |

## Verification
The bench builds the block with PERIOD = 16, DAC_W = 6 and IREF_CODE = 40. With these values a whole chop period lasts 16 clocks and every duty point is a whole multiple of 4. Counting on-cycles over any 16 consecutive clocks then gives the exact duty whatever the phase alignment. The short period also lets the bench observe several trip-and-re-arm sequences and duty changes in a few hundred cycles. The default PERIOD gives an 8 kHz chop rate at 250 MHz.

// File: rtl/stepper_chopper_pkg.sv
package stepper_chopper_pkg;

  typedef enum logic [1:0] {
    PH_AP_BP = 2'd0,
    PH_AN_BP = 2'd1,
    PH_AN_BN = 2'd2,
    PH_AP_BN = 2'd3
  } phase_e;

  function automatic logic pol_of_a(input phase_e ph);
    return (ph == PH_AP_BP) || (ph == PH_AP_BN);
  endfunction

  function automatic logic pol_of_b(input phase_e ph);
    return (ph == PH_AP_BP) || (ph == PH_AN_BP);
  endfunction

endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last <= 1'b0;
    else        last <= chain[STAGES-1];

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~last;
endmodule

// File: rtl/phase_seq.sv
module phase_seq
  import stepper_chopper_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   advance,
  input  logic   forward,
  output phase_e phase,
  output logic   pol_a,
  output logic   pol_b
);
  phase_e phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_AP_BP;
    end else if (advance) begin
      if (forward) phase_q <= phase_e'(phase_q + 2'd1);
      else         phase_q <= phase_e'(phase_q - 2'd1);
    end
  end

  assign phase = phase_q;
  assign pol_a = pol_of_a(phase_q);
  assign pol_b = pol_of_b(phase_q);
endmodule

// File: rtl/chop_timer.sv
module chop_timer #(
  parameter int PERIOD = 16,
  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       duty_sel,
  input  logic             trip,
  output logic             drive_on,
  output logic             tripped,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W:0]   limit
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W:0]   Q1   = (CNT_W+1)'(PERIOD / 4);
  localparam logic [CNT_W:0]   Q2   = (CNT_W+1)'(PERIOD / 2);
  localparam logic [CNT_W:0]   Q3   = (CNT_W+1)'((3 * PERIOD) / 4);
  localparam logic [CNT_W:0]   Q4   = (CNT_W+1)'(PERIOD);

  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       duty_q;
  logic             trip_q;
  logic             wrap;

  assign wrap = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      duty_q <= 2'd0;
      trip_q <= 1'b0;
    end else if (!run) begin
      cnt_q  <= '0;
      duty_q <= duty_sel;
      trip_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      duty_q <= duty_sel;
      trip_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (trip) trip_q <= 1'b1;
    end
  end

  always_comb begin
    case (duty_q)
      2'd0:    limit = Q1;
      2'd1:    limit = Q2;
      2'd2:    limit = Q3;
      default: limit = Q4;
    endcase
  end

  assign drive_on = run && ({1'b0, cnt_q} < limit) && !trip_q;
  assign tripped  = trip_q;
  assign count    = cnt_q;
endmodule

// File: rtl/stepper_chopper_drive.sv
module stepper_chopper_drive
  import stepper_chopper_pkg::*;
#(
  parameter int          PERIOD    = 31250,
  parameter int          DAC_W     = 6,
  parameter int          SYNC_LEN  = 2,
  parameter logic [DAC_W-1:0] IREF_CODE = DAC_W'(40)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_in,
  input  logic             dir_in,
  input  logic             enable,
  input  logic [1:0]       duty_sel,
  input  logic             comp_trip,
  output logic             pol_a,
  output logic             pol_b,
  output logic             bridge_en_a,
  output logic             bridge_en_b,
  output logic [DAC_W-1:0] dac_ref
);
  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic             step_rise;
  logic             step_level;
  logic             trip_level;
  logic             trip_rise;
  logic             drive_on;
  logic             tripped;
  logic [CNT_W-1:0] chop_count;
  logic [CNT_W:0]   chop_limit;
  phase_e           phase;

  sync_edge #(.STAGES(SYNC_LEN)) u_step_sync (
    .clk(clk), .rst_n(rst_n), .async_in(step_in),
    .level(step_level), .rise(step_rise)
  );

  sync_edge #(.STAGES(SYNC_LEN)) u_trip_sync (
    .clk(clk), .rst_n(rst_n), .async_in(comp_trip),
    .level(trip_level), .rise(trip_rise)
  );

  phase_seq u_phase (
    .clk(clk), .rst_n(rst_n),
    .advance(step_rise && enable), .forward(dir_in),
    .phase(phase), .pol_a(pol_a), .pol_b(pol_b)
  );

  chop_timer #(.PERIOD(PERIOD)) u_chop (
    .clk(clk), .rst_n(rst_n), .run(enable), .duty_sel(duty_sel),
    .trip(trip_level), .drive_on(drive_on), .tripped(tripped),
    .count(chop_count), .limit(chop_limit)
  );

  assign bridge_en_a = drive_on;
  assign bridge_en_b = drive_on;
  assign dac_ref     = enable ? IREF_CODE : '0;
endmodule

// File: rtl/stepper_chopper_checker.sv
module stepper_chopper_checker #(
  parameter int DAC_W = 6,
  parameter int CNT_W = 4,
  parameter logic [DAC_W-1:0] IREF_CODE = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             pol_a,
  input logic             pol_b,
  input logic             bridge_en_a,
  input logic             bridge_en_b,
  input logic [DAC_W-1:0] dac_ref,
  input logic             tripped,
  input logic [CNT_W-1:0] chop_count,
  input logic [CNT_W:0]   chop_limit
);
  // R2: full-step moves flip exactly one winding polarity
  p_one_winding_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pol_a, pol_b} ^ $past({pol_a, pol_b})) <= 1);

  // R4: a disabled cycle cannot move the phase
  p_hold_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> $stable({pol_a, pol_b}));

  // R4: disabled means bridges off
  p_off_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!bridge_en_a && !bridge_en_b));

  // R5: on-time never runs past the duty compare point
  p_duty_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bridge_en_a |-> ({1'b0, chop_count} < chop_limit));

  // R7: a latched trip keeps the bridges off
  p_trip_blanks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tripped |-> !bridge_en_a);

  // R8: reference code while running
  p_dac_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> (dac_ref == IREF_CODE));

  // R9: both windings chopped together
  p_same_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bridge_en_a == bridge_en_b);
endmodule

bind stepper_chopper_drive stepper_chopper_checker #(
  .DAC_W(DAC_W), .CNT_W(CNT_W), .IREF_CODE(IREF_CODE)
) u_checker (
  .clk(clk), .rst_n(rst_n), .enable(enable),
  .pol_a(pol_a), .pol_b(pol_b),
  .bridge_en_a(bridge_en_a), .bridge_en_b(bridge_en_b),
  .dac_ref(dac_ref), .tripped(tripped),
  .chop_count(chop_count), .chop_limit(chop_limit)
);

// File: tb/test_stepper_chopper_drive.sv
`timescale 1ns/1ps
module test_stepper_chopper_drive;
  localparam int PERIOD = 16;
  localparam int DAC_W  = 6;
  localparam logic [DAC_W-1:0] IREF = 6'd40;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             step_in = 1'b0;
  logic             dir_in = 1'b1;
  logic             enable = 1'b0;
  logic [1:0]       duty_sel = 2'd0;
  logic             comp_trip = 1'b0;
  logic             pol_a, pol_b, bridge_en_a, bridge_en_b;
  logic [DAC_W-1:0] dac_ref;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  stepper_chopper_drive #(
    .PERIOD(PERIOD), .DAC_W(DAC_W), .IREF_CODE(IREF)
  ) i_stepper_chopper_drive (
    .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_in(dir_in),
    .enable(enable), .duty_sel(duty_sel), .comp_trip(comp_trip),
    .pol_a(pol_a), .pol_b(pol_b), .bridge_en_a(bridge_en_a),
    .bridge_en_b(bridge_en_b), .dac_ref(dac_ref)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_step(input int high_cycles);
    @(negedge clk); step_in = 1'b1;
    repeat (high_cycles) @(negedge clk);
    step_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic count_on(output int n, output int mismatch);
    n = 0; mismatch = 0;
    for (int i = 0; i < PERIOD; i++) begin
      @(negedge clk);
      if (bridge_en_a) n++;
      if (bridge_en_a != bridge_en_b) mismatch++;
    end
  endtask

  task automatic t_reset();
    check("R1 pol", {pol_a, pol_b}, 2'b11);
    check("R1 bridge", {bridge_en_a, bridge_en_b}, 0);
    check("R1 dac", dac_ref, 0);
  endtask

  task automatic t_forward();
    enable = 1'b1; dir_in = 1'b1;
    pulse_step(1); check("R2 fwd1", {pol_a, pol_b}, 2'b01);
    pulse_step(1); check("R2 fwd2", {pol_a, pol_b}, 2'b00);
    pulse_step(1); check("R2 fwd3", {pol_a, pol_b}, 2'b10);
    pulse_step(1); check("R2 fwd4", {pol_a, pol_b}, 2'b11);
  endtask

  task automatic t_reverse();
    dir_in = 1'b0;
    pulse_step(1); check("R2 rev1", {pol_a, pol_b}, 2'b10);
    pulse_step(1); check("R2 rev2", {pol_a, pol_b}, 2'b00);
  endtask

  task automatic t_held_step();
    dir_in = 1'b1;
    pulse_step(12); check("R3 held step one move", {pol_a, pol_b}, 2'b10);
  endtask

  task automatic t_disabled();
    @(negedge clk); enable = 1'b0; #0.5;
    check("R4 bridge off", {bridge_en_a, bridge_en_b}, 0);
    check("R8 dac zero", dac_ref, 0);
    pulse_step(1); pulse_step(1);
    check("R4 phase kept", {pol_a, pol_b}, 2'b10);
    check("R4 still off", {bridge_en_a, bridge_en_b}, 0);
  endtask

  task automatic t_duty(input logic [1:0] sel);
    int n, mm;
    @(negedge clk); enable = 1'b0; duty_sel = sel;
    @(negedge clk); enable = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 dac code", dac_ref, IREF);
    count_on(n, mm);
    check("R5 duty on-cycles", n, (PERIOD / 4) * (sel + 1));
    check("R9 enables equal", mm, 0);
  endtask

  task automatic t_duty_change();
    int n, mm;
    @(negedge clk); duty_sel = 2'd2;
    repeat (PERIOD + 2) @(negedge clk);
    count_on(n, mm);
    check("R6 new duty next period", n, 12);
  endtask

  task automatic t_trip();
    int n, mm;
    @(negedge clk); duty_sel = 2'd1; comp_trip = 1'b1;
    repeat (2 * PERIOD) @(negedge clk);
    count_on(n, mm);
    check("R7 trip cuts period", n, 1);
    @(negedge clk); comp_trip = 1'b0;
    repeat (PERIOD + 4) @(negedge clk);
    count_on(n, mm);
    check("R7 rearm", n, PERIOD / 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_forward();
    t_reverse();
    t_held_step();
    t_disabled();
    t_duty(2'd0);
    t_duty(2'd1);
    t_duty(2'd2);
    t_duty(2'd3);
    t_duty_change();
    t_trip();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule